// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column addresses of one SDRAM read or write burst. An access command, qualified by the clock enable, loads a 9-bit starting column. The same command loads a 3-bit burst-length code and a one-bit ordering select. On each enabled rising clock edge after that, the block moves to the next column of the burst. It raises a last-beat flag on the final column, and its output becomes idle when the burst is complete.

Two orderings are available. Sequential ordering counts the low bits of the column upward and wraps them inside the aligned burst window. Interleaved ordering XORs the beat number into those low bits. The full-page code steps through all 512 columns of the row and keeps wrapping until a terminate or a new start ends it. While the clock enable is low, the block stops in place and ignores every command input.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and after reset is released, col_valid and col_last are 0 and col is 0.
- R2: A start sampled on a rising edge with clk_en high makes col_valid 1 on the next cycle, and col then equals the sampled start_col (beat 0).
- R3: The length code sets the number of beats: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. Codes 4, 5 and 6 give 1 beat. After the final beat, col_valid goes to 0.
- R4: With order_xor = 0 and a fixed length BL, beat b outputs the column whose low log2(BL) bits are (start low bits + b) mod BL. The upper bits are those of start_col.
- R5: With order_xor = 1 and a fixed length BL, beat b outputs the column whose low log2(BL) bits are (start low bits XOR b). The upper bits are those of start_col.
- R6: Code 7 selects full page. Beat b outputs (start_col + b) mod 512, order_xor has no effect, col_last stays 0, and the burst keeps running until it is terminated or restarted.
- R7: col_last is 1 exactly on the final beat of a fixed-length burst, while col_valid is 1.
- R8: A term sampled with clk_en high during a burst and without start makes col_valid 0 on the next cycle.
- R9: A start sampled during a burst discards that burst and begins a new one from the new start_col. When start and term are sampled together, start takes precedence.
- R10: While clk_en is low, col, col_valid and col_last hold their values, and start and term have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes the block |
| start | input | 1 | Access command strobe that loads a new burst |
| start_col | input | 9 | Starting column for the burst |
| len_code | input | 3 | Burst length code |
| order_xor | input | 1 | 0 selects sequential ordering, 1 selects interleaved ordering |
| term | input | 1 | Ends the burst in progress |
| col | output | 9 | Current column address |
| col_valid | output | 1 | col holds a beat of a live burst |
| col_last | output | 1 | col is the final beat of the burst |

## Verification
The clash that matters most is a new start or a terminate arriving in the same cycle as the advance of an ongoing burst. It is made worse when both commands arrive on one edge, or when they arrive while clk_en is low. The bench creates these cases by asserting start in the middle of a burst, by asserting start and term together, and by holding start and term high while clk_en is low. In each case it compares the next visible column, valid flag and last flag with values computed from the requirements: the restart wins, the terminate alone ends the burst, and a disabled clock changes nothing.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;

  localparam int          CODE_W        = 3;
  localparam logic [2:0]  CODE_FULLPAGE = 3'd7;
  localparam int          MAX_FIXED_LOG = 3;
endpackage

// File: rtl/colgen_len_dec.sv
module colgen_len_dec
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [COL_W-1:0]  wrap_mask,
  output logic              full_page
);
  logic fixed_len;
  int   log_len;

  always_comb begin
    full_page = (code == CODE_FULLPAGE);
    fixed_len = (int'(code) <= MAX_FIXED_LOG);
    log_len   = fixed_len ? int'(code) : 0;
  end

  // One mask bit per column bit: ones cover the bits that wrap in the burst
  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign wrap_mask[g] = full_page | (g < log_len);
  end
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             start,
  input  logic             term,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  order_e           ord_in,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q,
  output order_e           ord_q,
  output logic             valid_q,
  output logic             last_beat
);
  logic [COL_W-1:0] base_d, beat_d, mask_d;
  logic             full_d, valid_d, at_end;
  order_e           ord_d;

  assign at_end    = !full_q && (beat_q == mask_q);
  assign last_beat = valid_q && at_end;

  always_comb begin
    base_d  = base_q;
    beat_d  = beat_q;
    mask_d  = mask_q;
    full_d  = full_q;
    ord_d   = ord_q;
    valid_d = valid_q;
    if (clk_en) begin
      if (start) begin
        base_d  = start_col;
        beat_d  = '0;
        mask_d  = mask_in;
        full_d  = full_in;
        ord_d   = ord_in;
        valid_d = 1'b1;
      end else if (valid_q) begin
        if (term || at_end) valid_d = 1'b0;
        else                beat_d  = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      ord_q   <= ORD_SEQ;
      valid_q <= 1'b0;
    end else begin
      base_q  <= base_d;
      beat_q  <= beat_d;
      mask_q  <= mask_d;
      full_q  <= full_d;
      ord_q   <= ord_d;
      valid_q <= valid_d;
    end
  end

  // R2: an enabled start opens a burst at beat zero
  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && start |=> valid_q && (beat_q == '0));
  // R8: a terminate without start closes the burst
  a_r8_term: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && term && !start && valid_q |=> !valid_q);
  // R7: after the final beat the burst is over
  a_r7_last_end: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && last_beat && !start |=> !valid_q);
  // R10: a disabled clock freezes the counter
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(beat_q) && $stable(valid_q));
  // R3: a fixed-length beat never leaves the wrap window
  a_r3_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !full_q |-> ((beat_q & ~mask_q) == '0));
endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             full_page,
  input  order_e           ord,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_col, xor_col;
  logic             use_xor;

  // Carries out of the window fall on masked bits, so a plain add wraps
  assign seq_col = base + beat;
  assign xor_col = base ^ beat;
  assign use_xor = (ord == ORD_XOR) && !full_page;

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    assign col[g] = !wrap_mask[g] ? base[g] : (use_xor ? xor_col[g] : seq_col[g]);
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] len_code,
  input  logic              order_xor,
  input  logic              term,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              col_last
);
  logic [COL_W-1:0] dec_mask, base_q, beat_q, mask_q;
  logic             dec_full, full_q;
  order_e           ord_q, ord_in;

  assign ord_in = order_e'(order_xor);

  colgen_len_dec #(.COL_W(COL_W)) u_len_dec (
    .code      (len_code),
    .wrap_mask (dec_mask),
    .full_page (dec_full)
  );

  colgen_beat_ctr #(.COL_W(COL_W)) u_beat_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .start     (start),
    .term      (term),
    .start_col (start_col),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .ord_in    (ord_in),
    .base_q    (base_q),
    .beat_q    (beat_q),
    .mask_q    (mask_q),
    .full_q    (full_q),
    .ord_q     (ord_q),
    .valid_q   (col_valid),
    .last_beat (col_last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_addr_map (
    .base      (base_q),
    .beat      (beat_q),
    .wrap_mask (mask_q),
    .full_page (full_q),
    .ord       (ord_q),
    .col       (col)
  );

  // R2: the first beat presents the sampled start column
  a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en && start |=> col == $past(start_col));
  // R10: outputs hold while the clock is disabled
  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(col) && $stable(col_valid) && $stable(col_last));
endmodule

// File: tb/test_sdram_burst_colgen.sv
`timescale 1ns/1ps
module test_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n, clk_en, start, order_xor, term;
  logic [8:0] start_col, col;
  logic [2:0] len_code;
  logic       col_valid, col_last;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_burst_colgen i_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .start(start),
    .start_col(start_col), .len_code(len_code), .order_xor(order_xor),
    .term(term), .col(col), .col_valid(col_valid), .col_last(col_last)
  );

  // Each entry: {beats[3:0], order_xor, len_code[2:0], start_col[8:0]}
  localparam logic [16:0] VEC [0:7] = '{
    {4'd4, 1'b0, 3'd2, 9'h005},
    {4'd4, 1'b1, 3'd2, 9'h005},
    {4'd8, 1'b0, 3'd3, 9'h1F3},
    {4'd8, 1'b1, 3'd3, 9'h0A6},
    {4'd2, 1'b0, 3'd1, 9'h011},
    {4'd1, 1'b0, 3'd0, 9'h100},
    {4'd1, 1'b1, 3'd5, 9'h07F},
    {4'd2, 1'b1, 3'd1, 9'h0C2}
  };

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic ev, input logic [8:0] ec, input logic el);
    chk(col_valid == ev, {req, " valid"}, {8'd0, col_valid}, {8'd0, ev});
    chk(col_last == el, {req, " last"}, {8'd0, col_last}, {8'd0, el});
    if (ev) chk(col == ec, {req, " col"}, col, ec);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [16:0] e;
    logic [8:0]  m, ec;
    int          bl;
    rst_n = 1'b0; clk_en = 1'b1; start = 1'b0; term = 1'b0;
    start_col = '0; len_code = '0; order_xor = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk_out("R1 in reset", 1'b0, 9'h0, 1'b0);
    chk(col == 9'h0, "R1 col", col, 9'h0);
    @(negedge clk) rst_n = 1'b1;
    tick();
    chk_out("R1 after reset", 1'b0, 9'h0, 1'b0);

    // Table walk: R2, R3, R4, R5, R7
    for (int v = 0; v < 8; v++) begin
      e  = VEC[v];
      bl = int'(e[16:13]);
      m  = 9'(bl - 1);
      start = 1'b1; start_col = e[8:0]; len_code = e[11:9]; order_xor = e[12];
      for (int b = 0; b < bl; b++) begin
        tick();
        start = 1'b0;
        ec = (e[8:0] & ~m) | ((e[12] ? (e[8:0] ^ 9'(b)) : (e[8:0] + 9'(b))) & m);
        chk_out(b == 0 ? "R2" : (e[12] ? "R5" : "R4"), 1'b1, ec, (b == bl - 1));
        if (b == bl - 1) chk(col_last == 1'b1, "R7 final beat", {8'd0, col_last}, 9'h1);
      end
      tick();
      chk_out("R3 burst over", 1'b0, 9'h0, 1'b0);
    end

    // R6: full page wraps across 511 -> 0, ignores order_xor; R8 terminate
    start = 1'b1; start_col = 9'h1FE; len_code = 3'd7; order_xor = 1'b1;
    for (int b = 0; b < 5; b++) begin
      tick();
      start = 1'b0;
      chk_out("R6", 1'b1, 9'(9'h1FE + 9'(b)), 1'b0);
    end
    term = 1'b1;
    tick();
    term = 1'b0;
    chk_out("R8 term", 1'b0, 9'h0, 1'b0);

    // R10: disabled clock while idle ignores start
    clk_en = 1'b0; start = 1'b1; start_col = 9'h0FF; len_code = 3'd0;
    tick();
    chk_out("R10 idle start ignored", 1'b0, 9'h0, 1'b0);
    clk_en = 1'b1; start = 1'b0;
    tick();
    chk_out("R10 stays idle", 1'b0, 9'h0, 1'b0);

    // R10: freeze mid-burst with start and term held
    start = 1'b1; start_col = 9'h020; len_code = 3'd3; order_xor = 1'b0;
    tick();
    start = 1'b0;
    chk_out("R2", 1'b1, 9'h020, 1'b0);
    tick();
    chk_out("R4", 1'b1, 9'h021, 1'b0);
    clk_en = 1'b0; start = 1'b1; start_col = 9'h1AA; term = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_out("R10 hold", 1'b1, 9'h021, 1'b0);
    end
    clk_en = 1'b1; start = 1'b0; term = 1'b0;
    tick();
    chk_out("R10 resume", 1'b1, 9'h022, 1'b0);

    // R9: restart mid-burst
    start = 1'b1; start_col = 9'h150; len_code = 3'd1;
    tick();
    start = 1'b0;
    chk_out("R9 restart", 1'b1, 9'h150, 1'b0);
    tick();
    chk_out("R9 second beat", 1'b1, 9'h151, 1'b1);
    tick();
    chk_out("R9 done", 1'b0, 9'h0, 1'b0);

    // R9: start and term together, start wins
    start = 1'b1; start_col = 9'h008; len_code = 3'd2;
    tick();
    chk_out("R2", 1'b1, 9'h008, 1'b0);
    term = 1'b1; start_col = 9'h030; len_code = 3'd0;
    tick();
    start = 1'b0; term = 1'b0;
    chk_out("R9 start over term", 1'b1, 9'h030, 1'b1);
    tick();
    chk_out("R3 single beat over", 1'b0, 9'h0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule